// File: doc/BRIEF.md
# UART Interrupt Request Controller

This block turns the status of a UART into three level-sensitive service requests: one for the transmit side, one for the receive side and one for line errors. It holds the three-bit enable register and the line-status flags: holding-register-empty, data-ready and three sticky error bits. A request is raised when its flag goes from 0 to 1. The transmit request is also raised the moment its enable is switched on while the holding register is empty. Software can therefore start a string by setting the enable and loading the first character from its service routine.

Each request is withdrawn by the register access that services it. A holding-register write clears the transmit request, a receive-buffer read clears the receive request, and a line-status read clears the error request. An identification read withdraws a transmit request that nobody intends to answer. The identification readback reports the most urgent pending source. The serial engines, the baud divider and the DMA channels sit outside this block. They drive the event inputs and consume the request outputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset `thr_empty` is 1. `data_ready`, `err_bits`, `ier_q`, `iir` and all three requests are 0.
- R2: An enable write that changes bit 0 from 0 to 1 while `thr_empty` is 1 sets `tx_req` at the same clock edge that updates `ier_q`.
- R3: With bit 0 enabled, a `thr_load` pulse sets `thr_empty` at its edge. `tx_req` follows one clock later, because the edge is detected against the registered previous flag.
- R4: A `thr_wr` pulse clears both `thr_empty` and `tx_req`. When `thr_wr` and `thr_load` arrive in the same cycle, `thr_empty` ends up 0.
- R5: A pending `tx_req` is dropped at the edge where an enable write clears bit 0.
- R6: With bit 1 enabled, a `rx_byte` pulse sets `data_ready` at its edge and `rx_req` one clock later. A `rbr_rd` clears both. A `rbr_rd` and a `rx_byte` in the same cycle leave `data_ready` at 1, and `rx_req` is raised again one clock later.
- R7: `err_bits` holds framing in bit 0, parity in bit 1 and overrun in bit 2. The bits are sticky and accumulate. With bit 2 enabled, `ls_req` rises one clock after any error bit goes from 0 to 1.
- R8: A `lsr_rd` clears `err_bits` and `ls_req`. An error that arrives in the same cycle as the read stays set, and it raises `ls_req` again one clock later.
- R9: `iir` has bit 0 set when any request is pending. Bits 2:1 name the source: 2'b11 for line status, 2'b10 for receive, 2'b01 for transmit, with priority in that order. The no-request code is 3'b000.
- R10: An `iir_rd` clears `tx_req` only when transmit is the reported source. The other requests are untouched by it.
- R11: Enable bits are: bit 0 transmit, bit 1 receive, bit 2 line status, read back on `ier_q`. A flag that rises while its source is disabled raises no request, including after the source is enabled later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 3 | Enable-register write data |
| thr_wr | input | 1 | Transmit holding register write |
| rbr_rd | input | 1 | Receive buffer read |
| lsr_rd | input | 1 | Line-status read |
| iir_rd | input | 1 | Identification read |
| thr_load | input | 1 | Core moved holding data into the shifter |
| rx_byte | input | 1 | Core received a new byte |
| err_frame | input | 1 | Framing error event |
| err_parity | input | 1 | Parity error event |
| err_overrun | input | 1 | Overrun error event |
| ier_q | output | 3 | Enable register readback |
| thr_empty | output | 1 | Holding register empty flag |
| data_ready | output | 1 | Receive data ready flag |
| err_bits | output | 3 | Sticky error bits |
| iir | output | 3 | Identification readback |
| tx_req | output | 1 | Transmit request |
| rx_req | output | 1 | Receive request |
| ls_req | output | 1 | Line-status request |

## Verification
The assertions run on every cycle and cover the clearing side effects. They check that a holding write empties the flag and drops the transmit request, that the two clearing reads drop their requests, and that a disabling write drops the transmit request. They also check that error bits never lose a bit without a status read, that the identification pending bit matches the requests, and that a receive request never rises while receive is disabled.

Some behaviour depends on the history of the flags, and only the bench scenarios show it. These scenarios cover the one-cycle lag from a flag edge to its request and the immediate request on enabling transmit. They also cover a new byte or error that coincides with its clearing read, and an edge that is lost while its source was disabled. A full sweep of pending-source combinations tests the priority and the selective effect of an identification read.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [2:0] ier_wdata,
  input  logic       thr_wr,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  input  logic       iir_rd,
  input  logic       thr_load,
  input  logic       rx_byte,
  input  logic       err_frame,
  input  logic       err_parity,
  input  logic       err_overrun,
  output logic [2:0] ier_q,
  output logic       thr_empty,
  output logic       data_ready,
  output logic [2:0] err_bits,
  output logic [2:0] iir,
  output logic       tx_req,
  output logic       rx_req,
  output logic       ls_req
);

  logic       thr_prev;
  logic       dr_prev;
  logic [2:0] err_prev;

  logic [2:0] err_in;
  logic [2:0] ier_nx;
  logic       tx_arm;
  logic       tx_rise;
  logic       dr_rise;
  logic [2:0] err_rise;
  logic       iir_tx_clr;

  assign err_in     = {err_overrun, err_parity, err_frame};
  assign ier_nx     = ier_wr ? ier_wdata : ier_q;
  assign tx_arm     = ier_wr & ier_wdata[0] & ~ier_q[0] & thr_empty;
  assign tx_rise    = thr_empty & ~thr_prev;
  assign dr_rise    = data_ready & ~dr_prev;
  assign err_rise   = err_bits & ~err_prev;
  assign iir_tx_clr = iir_rd & tx_req & ~rx_req & ~ls_req;

  always_comb begin
    if (ls_req)      iir = 3'b111;
    else if (rx_req) iir = 3'b101;
    else if (tx_req) iir = 3'b011;
    else             iir = 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q      <= 3'b000;
      thr_empty  <= 1'b1;
      thr_prev   <= 1'b1;
      data_ready <= 1'b0;
      dr_prev    <= 1'b0;
      err_bits   <= 3'b000;
      err_prev   <= 3'b000;
      tx_req     <= 1'b0;
      rx_req     <= 1'b0;
      ls_req     <= 1'b0;
    end else begin
      ier_q      <= ier_nx;
      thr_empty  <= ~thr_wr & (thr_load | thr_empty);
      thr_prev   <= thr_empty;
      data_ready <= rx_byte | (data_ready & ~rbr_rd);
      dr_prev    <= data_ready & ~rbr_rd;
      err_bits   <= err_in | (err_bits & {3{~lsr_rd}});
      err_prev   <= err_bits & {3{~lsr_rd}};
      tx_req     <= (tx_req | tx_arm | (ier_q[0] & tx_rise))
                    & ~thr_wr & ier_nx[0] & ~iir_tx_clr;
      rx_req     <= (rx_req | (ier_q[1] & dr_rise)) & ~rbr_rd & ier_nx[1];
      ls_req     <= (ls_req | (ier_q[2] & |err_rise)) & ~lsr_rd & ier_nx[2];
    end
  end

  a_r4_write_empties: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (!thr_empty && !tx_req));

  a_r5_disable_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && !ier_wdata[0]) |=> !tx_req);

  a_r6_read_drops_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd |=> !rx_req);

  a_r7_errors_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr_rd |=> ((err_bits & $past(err_bits)) == $past(err_bits)));

  a_r8_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd |=> (!ls_req && err_bits == $past(err_in)));

  a_r9_pending_bit: assert property (@(posedge clk) disable iff (!rst_n)
    iir[0] == (tx_req | rx_req | ls_req));

  a_r11_rx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_req) |-> $past(ier_q[1]));

endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 1'b0;
  logic [2:0] ier_wdata = 3'b000;
  logic thr_wr = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0, iir_rd = 1'b0;
  logic thr_load = 1'b0, rx_byte = 1'b0;
  logic err_frame = 1'b0, err_parity = 1'b0, err_overrun = 1'b0;
  logic [2:0] ier_q, err_bits, iir;
  logic thr_empty, data_ready, tx_req, rx_req, ls_req;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .thr_wr(thr_wr), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .iir_rd(iir_rd),
    .thr_load(thr_load), .rx_byte(rx_byte), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun), .ier_q(ier_q),
    .thr_empty(thr_empty), .data_ready(data_ready), .err_bits(err_bits),
    .iir(iir), .tx_req(tx_req), .rx_req(rx_req), .ls_req(ls_req));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ier(input logic [2:0] v);
    ier_wr = 1'b1; ier_wdata = v;
    cyc(1);
    ier_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(1);
    do_reset();
    // R1 reset state
    chk("R1 thr_empty", thr_empty, 1);
    chk("R1 flags", {data_ready, err_bits, ier_q}, 0);
    chk("R1 requests", {tx_req, rx_req, ls_req, iir}, 0);

    // R2 immediate transmit request
    wr_ier(3'b001);
    chk("R2 tx_req on enable", tx_req, 1);
    chk("R9 iir tx", iir, 3'b011);

    // R4 write clears
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0;
    chk("R4 thr_empty cleared", thr_empty, 0);
    chk("R4 tx_req cleared", tx_req, 0);

    // R3 edge with lag
    thr_load = 1'b1; cyc(1); thr_load = 1'b0;
    chk("R3 flag set", thr_empty, 1);
    chk("R3 no req yet", tx_req, 0);
    cyc(1);
    chk("R3 req after lag", tx_req, 1);

    // R10 identification read drops transmit
    iir_rd = 1'b1; cyc(1); iir_rd = 1'b0;
    chk("R10 iir read drops tx", tx_req, 0);
    chk("R10 flag kept", thr_empty, 1);

    // R5 disabling drops transmit
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0;
    thr_load = 1'b1; cyc(1); thr_load = 1'b0;
    cyc(1);
    chk("R5 req before disable", tx_req, 1);
    wr_ier(3'b000);
    chk("R5 disable drops tx", tx_req, 0);
    wr_ier(3'b001);
    chk("R2 re-enable raises tx", tx_req, 1);

    // R4 simultaneous write and load
    thr_wr = 1'b1; thr_load = 1'b1; cyc(1); thr_wr = 1'b0; thr_load = 1'b0;
    chk("R4 write wins over load", thr_empty, 0);

    // R6 receive
    wr_ier(3'b010);
    rx_byte = 1'b1; cyc(1); rx_byte = 1'b0;
    chk("R6 data_ready", data_ready, 1);
    chk("R6 no req yet", rx_req, 0);
    cyc(1);
    chk("R6 rx_req", rx_req, 1);
    chk("R9 iir rx", iir, 3'b101);
    rbr_rd = 1'b1; cyc(1); rbr_rd = 1'b0;
    chk("R6 read clears", {data_ready, rx_req}, 0);
    rx_byte = 1'b1; cyc(1); rx_byte = 1'b0;
    cyc(1);
    rbr_rd = 1'b1; rx_byte = 1'b1; cyc(1); rbr_rd = 1'b0; rx_byte = 1'b0;
    chk("R6 concurrent keeps flag", data_ready, 1);
    chk("R6 concurrent drops req", rx_req, 0);
    cyc(1);
    chk("R6 concurrent re-raises", rx_req, 1);
    rbr_rd = 1'b1; cyc(1); rbr_rd = 1'b0;

    // R11 edge while disabled is lost
    wr_ier(3'b000);
    rx_byte = 1'b1; cyc(1); rx_byte = 1'b0;
    cyc(2);
    chk("R11 disabled no req", rx_req, 0);
    wr_ier(3'b010);
    chk("R11 ier readback", ier_q, 3'b010);
    cyc(2);
    chk("R11 no late req", {data_ready, rx_req}, 2'b10);
    rbr_rd = 1'b1; cyc(1); rbr_rd = 1'b0;

    // R7/R8 sweep over error patterns and enable
    for (int e = 0; e < 2; e++) begin
      for (int p = 1; p < 8; p++) begin
        wr_ier(e[0] ? 3'b100 : 3'b000);
        err_frame = p[0]; err_parity = p[1]; err_overrun = p[2];
        cyc(1);
        err_frame = 1'b0; err_parity = 1'b0; err_overrun = 1'b0;
        cyc(1);
        chk("R7 error bits", err_bits, p[2:0]);
        chk("R7 ls_req", ls_req, e[0]);
        chk("R9 iir ls", iir, e[0] ? 3'b111 : 3'b000);
        lsr_rd = 1'b1; cyc(1); lsr_rd = 1'b0;
        chk("R8 read clears", {err_bits, ls_req}, 0);
      end
    end

    // R7 sticky accumulate, R8 concurrent error
    wr_ier(3'b100);
    err_frame = 1'b1; cyc(1); err_frame = 1'b0;
    err_parity = 1'b1; cyc(1); err_parity = 1'b0;
    chk("R7 sticky accumulate", err_bits, 3'b011);
    lsr_rd = 1'b1; err_overrun = 1'b1; cyc(1); lsr_rd = 1'b0; err_overrun = 1'b0;
    chk("R8 concurrent error kept", err_bits, 3'b100);
    chk("R8 req dropped", ls_req, 0);
    cyc(1);
    chk("R8 req re-raised", ls_req, 1);
    lsr_rd = 1'b1; cyc(1); lsr_rd = 1'b0;

    // R9/R10 priority sweep
    for (int m = 0; m < 8; m++) begin
      do_reset();
      wr_ier(3'b111);
      if (!m[0]) begin thr_wr = 1'b1; cyc(1); thr_wr = 1'b0; end
      rx_byte = m[1]; err_frame = m[2];
      cyc(1);
      rx_byte = 1'b0; err_frame = 1'b0;
      cyc(1);
      chk("R9 priority", iir, m[2] ? 3'b111 : m[1] ? 3'b101 : m[0] ? 3'b011 : 3'b000);
      iir_rd = 1'b1; cyc(1); iir_rd = 1'b0;
      chk("R10 selective clear", {tx_req, rx_req, ls_req},
          {m[0] & (m[2] | m[1]), m[1], m[2]});
    end

    finish_run();
  end
endmodule